// File: doc/BRIEF.md
# Global Exclusive Access Monitor

This block sits beside an AHB-Lite slave and watches its traffic. It keeps exclusive-access reservations for a range of memory that one or more bus masters share. An exclusive load from a master records a reservation on the addressed granule for that master. An exclusive store from the same master succeeds only if that reservation is still in place. Any write that reaches memory in the covered range cancels every reservation on the granule it touches. A semaphore built from a load-exclusive / store-exclusive pair can therefore detect interference from other masters.

The monitor follows the address and data phases of each transfer. During the data phase it drives a one-bit exclusive response back to the master. It also drives a write-enable gate towards memory, and it holds that gate low for an exclusive store that fails, so a failed store leaves memory unchanged.

The response has a fixed polarity. A transfer that is not exclusive returns 0. An exclusive load returns 0 when its address is covered and 1 when it is not. An exclusive store returns 1 only when its address is covered and the reservation check fails.

Top module: `gx_monitor`

## Requirements
- R1: A transfer is accepted only in a cycle with `hready`=1 and `htrans[1]`=1 (NONSEQ 2'b10 or SEQ 2'b11). IDLE (2'b00), BUSY (2'b01) and any cycle with `hready`=0 record nothing, whatever `exclReq` is. The data phase follows, and the outputs stay stable through its wait states (`hready`=0).
- R2: In the data phase of a non-exclusive transfer, and when no data phase is active, `exclResp` is 0.
- R3: An exclusive load to a covered address (BASE <= addr < BASE+SIZE) gives `exclResp`=0. When it completes, it records a valid reservation for its `masterId` on granule addr >> GRAN_LOG2.
- R4: An exclusive load to an address outside the covered range gives `exclResp`=1 and records no reservation.
- R5: An exclusive store to a covered address passes when its master holds a valid reservation on the same granule. A passing store gives `exclResp`=0 and `memWrEn`=1, and it clears that reservation. Otherwise the store fails with `exclResp`=1 and `memWrEn`=0.
- R6: An exclusive store outside the covered range gives `exclResp`=0 and `memWrEn`=1.
- R7: Any write to a covered granule that reaches memory clears the reservation of every master on that granule. A plain write or a passing exclusive store counts as such a write. Reservations on other granules are kept.
- R8: `memWrEn` is 1 only in the data phase of a write that is not a failing exclusive store. It is 0 for reads and when no data phase is active.
- R9: After reset, no master holds a reservation and both outputs are 0.
- R10: A new covered exclusive load replaces the earlier reservation of the same master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| haddr | input | ADDR_W | Address-phase address |
| htrans | input | 2 | Address-phase transfer type |
| hwrite | input | 1 | Address-phase direction, 1 = write |
| hready | input | 1 | Transfer completion / address-phase qualifier |
| exclReq | input | 1 | Address-phase exclusive request |
| masterId | input | ID_W | Address-phase master identifier |
| exclResp | output | 1 | Data-phase exclusive response |
| memWrEn | output | 1 | Data-phase write enable gate to memory |

## Verification
The main function is first driven by directed sequences, each built to separate one pair of outcomes. A load followed by a store from one master separates a held reservation from a lost one. An intervening write to the same granule and one to a neighbouring granule separate granule-exact clearing from overly broad clearing. Loads from two masters to one granule show that a clear reaches every master on that granule. A covered and an uncovered address with the same operation tell the two response polarities apart. Constrained random transfers then mix masters, a handful of nearby granules, out-of-range addresses and wait states, which exposes wrong master indexing or ordering slips that the directed cases do not reach.

// File: rtl/gx_pkg.sv
package gx_pkg;
  // Strobes from control to the reservation datapath, valid for one cycle
  typedef struct packed {
    logic setRes;      // record reservation for current master/granule
    logic clrOwn;      // drop current master's reservation
    logic clrGranule;  // drop every reservation on current granule
  } gxStrobe_t;
endpackage

// File: rtl/gx_ctrl.sv
module gx_ctrl
  import gx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W = 2,
  parameter int GRAN_LOG2 = 3,
  parameter logic [ADDR_W-1:0] BASE = 32'h2000_0000,
  parameter logic [ADDR_W:0] SIZE = 33'h0_0001_0000
) (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0] htrans,
  input  logic hwrite,
  input  logic hready,
  input  logic exclReq,
  input  logic [ID_W-1:0] masterId,
  input  logic resPass,
  output logic [ID_W-1:0] dpId,
  output logic [ADDR_W-GRAN_LOG2-1:0] dpGran,
  output gxStrobe_t strobe,
  output logic exclResp,
  output logic memWrEn
);
  localparam int GRAN_W = ADDR_W - GRAN_LOG2;
  localparam logic [ADDR_W:0] LO_LIM = {1'b0, BASE};
  localparam logic [ADDR_W:0] HI_LIM = {1'b0, BASE} + SIZE;

  logic acceptA;
  logic addrCov;
  logic dpValid, dpWrite, dpExcl, dpCov;
  logic loadX, storeX, storeFail, xferDone;

  assign acceptA = hready && htrans[1];
  assign addrCov = ({1'b0, haddr} >= LO_LIM) && ({1'b0, haddr} < HI_LIM);

  // address phase capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpValid <= 1'b0;
      dpWrite <= 1'b0;
      dpExcl  <= 1'b0;
      dpCov   <= 1'b0;
      dpId    <= '0;
      dpGran  <= '0;
    end else if (hready) begin
      dpValid <= acceptA;
      dpWrite <= acceptA && hwrite;
      dpExcl  <= acceptA && exclReq;
      dpCov   <= addrCov;
      dpId    <= masterId;
      dpGran  <= haddr[ADDR_W-1:GRAN_LOG2];
    end
  end

  // data phase decisions
  always_comb begin
    loadX     = dpValid && dpExcl && !dpWrite;
    storeX    = dpValid && dpExcl && dpWrite;
    storeFail = storeX && dpCov && !resPass;
    exclResp  = (loadX && !dpCov) || storeFail;
    memWrEn   = dpValid && dpWrite && !storeFail;
    xferDone  = dpValid && hready;
    strobe.setRes     = xferDone && loadX && dpCov;
    strobe.clrOwn     = xferDone && storeX && dpCov && resPass;
    strobe.clrGranule = xferDone && memWrEn && dpCov;
  end

  logic unusedGw;
  assign unusedGw = ^{GRAN_W{1'b0}};
endmodule

// File: rtl/gx_datapath.sv
module gx_datapath
  import gx_pkg::*;
#(
  parameter int ID_W = 2,
  parameter int GRAN_W = 29
) (
  input  logic clk,
  input  logic rstN,
  input  gxStrobe_t strobe,
  input  logic [ID_W-1:0] dpId,
  input  logic [GRAN_W-1:0] dpGran,
  output logic resPass
);
  localparam int N_MST = 1 << ID_W;

  logic [N_MST-1:0] resValid;
  logic [GRAN_W-1:0] resGran [N_MST];

  for (genvar m = 0; m < N_MST; m++) begin : g_entry
    logic ownSel, granHit;
    assign ownSel  = (dpId == ID_W'(m));
    assign granHit = resValid[m] && (resGran[m] == dpGran);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resValid[m] <= 1'b0;
        resGran[m]  <= '0;
      end else if (strobe.setRes && ownSel) begin
        resValid[m] <= 1'b1;
        resGran[m]  <= dpGran;
      end else if ((strobe.clrOwn && ownSel) || (strobe.clrGranule && granHit)) begin
        resValid[m] <= 1'b0;
      end
    end
  end

  assign resPass = resValid[dpId] && (resGran[dpId] == dpGran);
endmodule

// File: rtl/gx_monitor.sv
module gx_monitor
  import gx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W = 2,
  parameter int GRAN_LOG2 = 3,
  parameter logic [ADDR_W-1:0] BASE = 32'h2000_0000,
  parameter logic [ADDR_W:0] SIZE = 33'h0_0001_0000
) (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0] htrans,
  input  logic hwrite,
  input  logic hready,
  input  logic exclReq,
  input  logic [ID_W-1:0] masterId,
  output logic exclResp,
  output logic memWrEn
);
  localparam int GRAN_W = ADDR_W - GRAN_LOG2;

  gxStrobe_t strobe;
  logic [ID_W-1:0] dpId;
  logic [GRAN_W-1:0] dpGran;
  logic resPass;

  gx_ctrl #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .GRAN_LOG2(GRAN_LOG2), .BASE(BASE), .SIZE(SIZE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hready(hready), .exclReq(exclReq), .masterId(masterId), .resPass(resPass),
    .dpId(dpId), .dpGran(dpGran), .strobe(strobe), .exclResp(exclResp),
    .memWrEn(memWrEn)
  );

  gx_datapath #(
    .ID_W(ID_W), .GRAN_W(GRAN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dpId(dpId), .dpGran(dpGran),
    .resPass(resPass)
  );
endmodule

// File: rtl/gx_monitor_chk.sv
module gx_monitor_chk #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'h2000_0000,
  parameter logic [ADDR_W:0] SIZE = 33'h0_0001_0000
) (
  input logic clk,
  input logic rstN,
  input logic [ADDR_W-1:0] haddr,
  input logic [1:0] htrans,
  input logic hwrite,
  input logic hready,
  input logic exclReq,
  input logic exclResp,
  input logic memWrEn
);
  logic cValid, cWrite, cExcl, cCov;
  logic inRng;
  assign inRng = ({1'b0, haddr} >= {1'b0, BASE}) && ({1'b0, haddr} < ({1'b0, BASE} + SIZE));

  // independent tracking of the data phase from the port signals
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cValid <= 1'b0; cWrite <= 1'b0; cExcl <= 1'b0; cCov <= 1'b0;
    end else if (hready) begin
      cValid <= htrans[1];
      cWrite <= hwrite;
      cExcl  <= exclReq;
      cCov   <= inRng;
    end
  end

  assert_wait_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cValid && !hready) |=> ($stable(exclResp) && $stable(memWrEn)));
  assert_plain_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(cValid && cExcl) |-> !exclResp);
  assert_load_cov_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cValid && cExcl && !cWrite && cCov) |-> !exclResp);
  assert_load_uncov_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cValid && cExcl && !cWrite && !cCov) |-> exclResp);
  assert_store_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cValid && cExcl && cWrite && cCov) |-> (exclResp != memWrEn));
  assert_store_uncov_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cValid && cExcl && cWrite && !cCov) |-> (!exclResp && memWrEn));
  assert_wren_write_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(cValid && cWrite) |-> !memWrEn);
endmodule

bind gx_monitor gx_monitor_chk #(.ADDR_W(ADDR_W), .BASE(BASE), .SIZE(SIZE)) u_chk (.*);

// File: tb/gx_monitor_tb.sv
`timescale 1ns/1ps
module gx_monitor_tb;
  localparam int ADDR_W = 32;
  localparam int ID_W = 2;
  localparam int GRAN_LOG2 = 3;
  localparam logic [31:0] BASE = 32'h2000_0000;
  localparam logic [32:0] SIZE = 33'h0_0001_0000;
  localparam int N_MST = 4;

  logic clk = 0;
  logic rstN = 0;
  logic [31:0] haddr = '0;
  logic [1:0] htrans = 2'b00;
  logic hwrite = 0, hready = 1, exclReq = 0;
  logic [ID_W-1:0] masterId = '0;
  logic exclResp, memWrEn;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit mValid [N_MST];
  logic [28:0] mGran [N_MST];

  always #2 clk = ~clk;

  gx_monitor u_dut (
    .clk(clk), .rstN(rstN), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hready(hready), .exclReq(exclReq), .masterId(masterId),
    .exclResp(exclResp), .memWrEn(memWrEn)
  );

  function automatic bit covered(input logic [31:0] a);
    return ({1'b0, a} >= {1'b0, BASE}) && ({1'b0, a} < ({1'b0, BASE} + SIZE));
  endfunction

  function automatic string reqOf(input bit w, input bit x, input bit cov);
    if (!x) return w ? "R8" : "R2";
    if (!w) return cov ? "R3" : "R4";
    return cov ? "R5" : "R6";
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // one transfer: address phase, then data phase with ws wait states
  task automatic xfer(input bit w, input bit x, input int id, input logic [31:0] a,
                      input int ws, input string tag);
    bit cov, pass, eResp, eWe;
    logic [28:0] g;
    cov = covered(a);
    g = a[31:GRAN_LOG2];
    pass = mValid[id] && (mGran[id] == g);
    eResp = 0; eWe = w;
    if (x && !w && !cov) eResp = 1;
    if (x && w && cov && !pass) begin eResp = 1; eWe = 0; end
    @(negedge clk);
    haddr = a; hwrite = w; exclReq = x; masterId = ID_W'(id); htrans = 2'b10; hready = 1;
    @(negedge clk);
    htrans = 2'b00; exclReq = 0;
    for (int k = 0; k < ws; k++) begin
      hready = 0;
      #1;
      check("R1", exclResp, eResp, "wait-state exclResp");
      @(negedge clk);
    end
    hready = 1;
    #1;
    check(tag == "" ? reqOf(w, x, cov) : tag, exclResp, eResp, "exclResp");
    check(tag == "" ? "R8" : tag, memWrEn, eWe, "memWrEn");
    // model update at completion
    if (x && !w && cov) begin mValid[id] = 1; mGran[id] = g; end
    if (x && w && cov && pass) mValid[id] = 0;
    if (w && eWe && cov)
      for (int m = 0; m < N_MST; m++) if (mValid[m] && mGran[m] == g) mValid[m] = 0;
  endtask

  localparam logic [31:0] A0 = 32'h2000_0040;
  localparam logic [31:0] A1 = 32'h2000_0048;
  localparam logic [31:0] UNC = 32'h3000_0000;

  initial begin
    for (int m = 0; m < N_MST; m++) begin mValid[m] = 0; mGran[m] = '0; end
    repeat (3) @(negedge clk);
    #1;
    check("R9", exclResp, 1'b0, "exclResp in reset");
    check("R9", memWrEn, 1'b0, "memWrEn in reset");
    rstN = 1;
    // R9: no reservation after reset
    for (int m = 0; m < N_MST; m++) xfer(1, 1, m, A0, 0, "R9");
    // R3 / R5 basic pair
    xfer(0, 1, 0, A0, 0, "R3");
    xfer(1, 1, 0, A0 + 4, 1, "R5");
    xfer(1, 1, 0, A0, 0, "R5");          // reservation consumed: fails
    // R7: two masters on one granule, plain write from a third
    xfer(0, 1, 0, A0, 0, "R3");
    xfer(0, 1, 1, A0, 0, "R3");
    xfer(0, 1, 2, A1, 0, "R3");
    xfer(1, 0, 3, A0 + 2, 0, "R7");
    xfer(1, 1, 0, A0, 0, "R7");
    xfer(1, 1, 1, A0, 0, "R7");
    xfer(1, 1, 2, A1, 0, "R7");          // other granule kept: passes
    // R4 / R6 outside range
    xfer(0, 1, 1, UNC, 0, "R4");
    xfer(1, 1, 1, UNC, 2, "R6");
    xfer(1, 1, 1, A0, 0, "R4");          // no reservation recorded by R4 load
    // R10 replacement
    xfer(0, 1, 3, A0, 0, "R10");
    xfer(0, 1, 3, A1, 0, "R10");
    xfer(1, 1, 3, A0, 0, "R10");
    xfer(1, 1, 3, A1, 0, "R10");
    // R1: IDLE / BUSY / unready NONSEQ exclusive loads record nothing
    @(negedge clk);
    haddr = A0; hwrite = 0; exclReq = 1; masterId = 2; htrans = 2'b00; hready = 1;
    @(negedge clk); htrans = 2'b01;
    @(negedge clk); htrans = 2'b10; hready = 0;
    @(negedge clk); htrans = 2'b00; exclReq = 0; hready = 1;
    #1;
    check("R1", exclResp, 1'b0, "exclResp after ignored phases");
    check("R1", memWrEn, 1'b0, "memWrEn after ignored phases");
    xfer(1, 1, 2, A0, 0, "R1");
    // constrained random
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      int r;
      r = $urandom_range(0, 9);
      a = (r == 0) ? UNC + 32'($urandom_range(0, 15)) :
          (r == 1) ? BASE + SIZE[31:0] - 32'd4 + 32'($urandom_range(0, 8)) :
                     A0 + 32'($urandom_range(0, 3) * 8 + $urandom_range(0, 7));
      xfer($urandom_range(0, 1) == 1, $urandom_range(0, 2) != 0,
           $urandom_range(0, N_MST - 1), a, $urandom_range(0, 2) == 0 ? 1 : 0, "");
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule